// File: doc/BRIEF.md
# Playback Data Block Deframer

This block sits behind the receive side of an isochronous audio link. It takes a stream of 32-bit quadlets, already stripped of packet headers, that form back-to-back data blocks, and sorts every quadlet of a block into one of three roles. A role is either a discarded leading word, an audio sample for one channel, or the single MIDI word that closes the block.

Software programs how many leading words each block carries before the payload, how many audio channels there are and how many MIDI ports are in use. It also sets a per-channel label-enable mask, the isochronous channel number of the stream and a global enable. Audio samples leave with their channel index and the label flag of that channel. A MIDI word leaves on its own strobe. Both appear one clock after the quadlet is accepted, and the bits are unchanged.

Top module: `pbd_deframer`

## Requirements
- R1: While reset is held and on the first cycle after it, `aud_valid` and `midi_valid` are low, and the first accepted quadlet after reset is position 0 of a block.
- R2: In every data block the first `cfg_skip` quadlets produce no output, and the payload begins at position `cfg_skip`.
- R3: The quadlet at block position `cfg_skip + k`, with k below `cfg_num_audio`, is output one clock after acceptance with `aud_valid` high, `aud_chan` = k and `aud_data` equal to the received quadlet bit for bit, without byte reordering.
- R4: When `cfg_midi_ports` is nonzero (any value 1 to 8), the quadlet at position `cfg_skip + cfg_num_audio` is output one clock later on `midi_valid`/`midi_data` and the block then ends. When it is 0, no MIDI quadlet exists and the next block starts right after the last audio quadlet.
- R5: When `cfg_iso_chan` is all ones (6'h3F), the stream is unused: no audio or MIDI output is produced.
- R6: While `cfg_enable` is low, no output is produced and the in-block position returns to 0. The first quadlet after enable is raised again is position 0 of a new block.
- R7: `aud_label` equals bit `aud_chan` of `cfg_label_mask` as it stood in the cycle the quadlet was accepted. A change of the mask affects the next quadlet without any restart.
- R8: Cycles with `q_valid` low neither advance the block position nor produce output, so a stream with gaps is split exactly like a continuous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_valid | input | 1 | Quadlet present this cycle |
| q_data | input | 32 | Received quadlet |
| cfg_enable | input | 1 | Global stream enable |
| cfg_iso_chan | input | 6 | Isochronous channel, all ones = unused |
| cfg_skip | input | 4 | Leading quadlets discarded per block |
| cfg_num_audio | input | 5 | Audio channels per block (0 to 16) |
| cfg_midi_ports | input | 4 | MIDI port count (0 to 8) |
| cfg_label_mask | input | 16 | Per-channel label-enable bits |
| aud_valid | output | 1 | Audio sample strobe |
| aud_chan | output | 4 | Channel index of the sample |
| aud_data | output | 32 | Audio sample quadlet |
| aud_label | output | 1 | Label flag of the sample's channel |
| midi_valid | output | 1 | MIDI quadlet strobe |
| midi_data | output | 32 | MIDI quadlet |

## Verification
The deframer is driven with blocks that have a skip region and no MIDI word, and with blocks that have audio plus MIDI and no skip region. Side by side, these show whether the payload start and the block length follow the configuration rather than a fixed layout. Switching the MIDI count between 8 and 0 on the same stream shows whether the extra word is counted only when the count is nonzero. A continuous burst is compared against the gapped single-quadlet pattern, which separates index advance on `q_valid` from advance on every clock. Disable in mid-block, an unused channel number and a mask change between two quadlets each show whether the gating and label paths act per quadlet.

// File: rtl/pbd_pkg.sv
// Package: shared types of the playback data block deframer.
// Assumes: nothing beyond IEEE 1800-2017.
package pbd_pkg;

    // Role of one quadlet within a data block
    typedef enum logic [1:0] {
        SLOT_DROP  = 2'd0,
        SLOT_AUDIO = 2'd1,
        SLOT_MIDI  = 2'd2
    } slot_e;

endpackage

// File: rtl/pbd_index_ctr.sv
// Module: in-block position counter.
// Counts accepted quadlets and wraps at the block length. It is held at 0
// whenever the stream is inactive, so that re-enabling starts a fresh block.
// Assumes: blk_len is the block length in quadlets; 0 means nothing is decoded.
module pbd_index_ctr #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             q_valid,
    input  logic [IDX_W-1:0] blk_len,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] idx_inc;

    // next position before the wrap check
    always_comb idx_inc = idx + IDX_W'(1);

    // advance on each accepted quadlet, wrap at the block end, clear when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (!active) begin
            idx <= '0;
        end else if (q_valid) begin
            if (idx_inc >= blk_len) idx <= '0;
            else                    idx <= idx_inc;
        end
    end

    // R6: an inactive cycle leaves the position at zero
    assert_idle_index_zero_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        !active |=> (idx == '0));

    // R8: a cycle without a quadlet does not move the position
    assert_gap_holds_index_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (active && !q_valid) |=> $stable(idx));

endmodule

// File: rtl/pbd_slot_decode.sv
// Module: quadlet role decoder.
// Maps a block position onto drop / audio / MIDI and the audio channel index.
// Assumes: positions below skip are dropped, the audio run follows, and the
// MIDI word comes after it only when the port count is nonzero.
module pbd_slot_decode
    import pbd_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int SK_W   = 4,
    parameter int NA_W   = 5,
    parameter int MIDI_W = 4,
    parameter int CH_W   = 4
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [SK_W-1:0]   skip,
    input  logic [NA_W-1:0]   num_audio,
    input  logic [MIDI_W-1:0] midi_ports,
    output slot_e             slot,
    output logic [CH_W-1:0]   chan
);

    logic [IDX_W-1:0] rel;
    logic             past_skip;

    // offset from the first payload word
    always_comb begin
        past_skip = (idx >= IDX_W'(skip));
        rel       = idx - IDX_W'(skip);
    end

    // classify the quadlet at this position
    always_comb begin
        slot = SLOT_DROP;
        if (past_skip) begin
            if (rel < IDX_W'(num_audio))
                slot = SLOT_AUDIO;
            else if ((midi_ports != '0) && (rel == IDX_W'(num_audio)))
                slot = SLOT_MIDI;
        end
    end

    // channel index of an audio word
    always_comb chan = rel[CH_W-1:0];

endmodule

// File: rtl/pbd_out_stage.sv
// Module: output register stage.
// Registers one audio sample or one MIDI word per accepted quadlet and
// attaches the label flag of the sample's channel.
// Assumes: slot and chan refer to the quadlet presented this cycle.
module pbd_out_stage
    import pbd_pkg::*;
#(
    parameter int QW     = 32,
    parameter int MAX_CH = 16,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              q_valid,
    input  logic [QW-1:0]     q_data,
    input  slot_e             slot,
    input  logic [CH_W-1:0]   chan,
    input  logic [MAX_CH-1:0] label_mask,
    output logic              aud_valid,
    output logic [CH_W-1:0]   aud_chan,
    output logic [QW-1:0]     aud_data,
    output logic              aud_label,
    output logic              midi_valid,
    output logic [QW-1:0]     midi_data
);

    logic take;

    // a quadlet is used only on an active stream
    always_comb take = active && q_valid;

    // strobes: one per accepted payload quadlet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aud_valid  <= 1'b0;
            midi_valid <= 1'b0;
        end else begin
            aud_valid  <= take && (slot == SLOT_AUDIO);
            midi_valid <= take && (slot == SLOT_MIDI);
        end
    end

    // audio payload register, loaded only for audio words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aud_chan  <= '0;
            aud_data  <= '0;
            aud_label <= 1'b0;
        end else if (take && (slot == SLOT_AUDIO)) begin
            aud_chan  <= chan;
            aud_data  <= q_data;
            aud_label <= label_mask[chan];
        end
    end

    // MIDI payload register, loaded only for the MIDI word
    always_ff @(posedge clk) begin
        if (!rst_n)                                midi_data <= '0;
        else if (take && (slot == SLOT_MIDI))      midi_data <= q_data;
    end

    // R8: any output strobe needs an accepted quadlet one cycle earlier
    assert_out_needs_quadlet_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (aud_valid || midi_valid) |-> $past(q_valid && active));

    // R6: an inactive cycle yields no output on the next one
    assert_idle_no_output_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        !active |=> (!aud_valid && !midi_valid));

endmodule

// File: rtl/pbd_deframer.sv
// Module: playback data block deframer (top).
// Splits a quadlet stream into skipped words, per-channel audio samples and an
// optional trailing MIDI word per data block.
// Assumes: headers are already removed; configuration is quasi-static except
// the label mask, which may change at any time.
module pbd_deframer
    import pbd_pkg::*;
#(
    parameter int QW       = 32,
    parameter int MAX_CH   = 16,
    parameter int SKIP_MAX = 15,
    parameter int ISO_W    = 6,
    parameter int MIDI_W   = 4,
    localparam int CH_W    = $clog2(MAX_CH),
    localparam int NA_W    = $clog2(MAX_CH + 1),
    localparam int SK_W    = $clog2(SKIP_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    input  logic [QW-1:0]     q_data,
    input  logic              cfg_enable,
    input  logic [ISO_W-1:0]  cfg_iso_chan,
    input  logic [SK_W-1:0]   cfg_skip,
    input  logic [NA_W-1:0]   cfg_num_audio,
    input  logic [MIDI_W-1:0] cfg_midi_ports,
    input  logic [MAX_CH-1:0] cfg_label_mask,
    output logic              aud_valid,
    output logic [CH_W-1:0]   aud_chan,
    output logic [QW-1:0]     aud_data,
    output logic              aud_label,
    output logic              midi_valid,
    output logic [QW-1:0]     midi_data
);

    localparam int IDX_W = $clog2(SKIP_MAX + MAX_CH + 2);

    logic             active;
    logic [IDX_W-1:0] blk_len;
    logic [IDX_W-1:0] idx;
    slot_e            slot;
    logic [CH_W-1:0]  chan;

    // stream runs when enabled and bound to a real channel number
    always_comb active = cfg_enable && (cfg_iso_chan != '1);

    // block length: skip + audio + one MIDI word when ports exist
    always_comb blk_len = IDX_W'(cfg_skip) + IDX_W'(cfg_num_audio)
                        + IDX_W'(cfg_midi_ports != '0);

    pbd_index_ctr #(
        .IDX_W (IDX_W)
    ) i_index_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .q_valid (q_valid),
        .blk_len (blk_len),
        .idx     (idx)
    );

    pbd_slot_decode #(
        .IDX_W  (IDX_W),
        .SK_W   (SK_W),
        .NA_W   (NA_W),
        .MIDI_W (MIDI_W),
        .CH_W   (CH_W)
    ) i_slot_decode (
        .idx        (idx),
        .skip       (cfg_skip),
        .num_audio  (cfg_num_audio),
        .midi_ports (cfg_midi_ports),
        .slot       (slot),
        .chan       (chan)
    );

    pbd_out_stage #(
        .QW     (QW),
        .MAX_CH (MAX_CH),
        .CH_W   (CH_W)
    ) i_out_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .q_valid    (q_valid),
        .q_data     (q_data),
        .slot       (slot),
        .chan       (chan),
        .label_mask (cfg_label_mask),
        .aud_valid  (aud_valid),
        .aud_chan   (aud_chan),
        .aud_data   (aud_data),
        .aud_label  (aud_label),
        .midi_valid (midi_valid),
        .midi_data  (midi_data)
    );

    // R3: an emitted channel index lies inside the configured channel count
    assert_chan_in_range_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        aud_valid |-> (NA_W'(aud_chan) < $past(cfg_num_audio)));

    // R4: a MIDI word only appears when ports were configured
    assert_midi_needs_ports_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        midi_valid |-> ($past(cfg_midi_ports) != '0));

    // R4: never an audio sample and a MIDI word together
    assert_single_strobe_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        $onehot0({aud_valid, midi_valid}));

    // R5: an unused channel number silences the outputs
    assert_unused_silent_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cfg_iso_chan == '1) |=> (!aud_valid && !midi_valid));

endmodule

// File: tb/test_pbd_deframer.sv
`timescale 1ns/1ps
module test_pbd_deframer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        q_valid;
    logic [31:0] q_data;
    logic        cfg_enable;
    logic [5:0]  cfg_iso_chan;
    logic [3:0]  cfg_skip;
    logic [4:0]  cfg_num_audio;
    logic [3:0]  cfg_midi_ports;
    logic [15:0] cfg_label_mask;
    logic        aud_valid;
    logic [3:0]  aud_chan;
    logic [31:0] aud_data;
    logic        aud_label;
    logic        midi_valid;
    logic [31:0] midi_data;

    int n_tests = 0;
    int n_fail  = 0;

    localparam int K_NONE = 0, K_AUD = 1, K_MIDI = 2;

    always #10 clk = ~clk;

    pbd_deframer i_pbd_deframer (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_data(q_data),
        .cfg_enable(cfg_enable), .cfg_iso_chan(cfg_iso_chan),
        .cfg_skip(cfg_skip), .cfg_num_audio(cfg_num_audio),
        .cfg_midi_ports(cfg_midi_ports), .cfg_label_mask(cfg_label_mask),
        .aud_valid(aud_valid), .aud_chan(aud_chan), .aud_data(aud_data),
        .aud_label(aud_label), .midi_valid(midi_valid), .midi_data(midi_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // compare the registered outputs against one expected quadlet role
    task automatic expect_out(input int kind, input logic [31:0] d, input int ch,
                              input bit lab, input string tag);
        logic [39:0] act, exp;
        act = {aud_valid, midi_valid, aud_chan, aud_label, 1'b0, 32'h0};
        exp = {kind == K_AUD, kind == K_MIDI, 4'(ch), lab, 1'b0, 32'h0};
        if (kind == K_AUD)  begin act[31:0] = aud_data;  exp[31:0] = d; end
        if (kind == K_MIDI) begin act[31:0] = midi_data; exp[31:0] = d; end
        if (kind != K_AUD) begin act[37:33] = '0; exp[37:33] = '0; end
        check(act == exp, tag, "{aud_v,midi_v,chan,label,data}", 64'(act), 64'(exp));
    endtask

    // one quadlet followed by an idle cycle, then check its result
    task automatic send_q(input logic [31:0] d, input int kind, input int ch,
                          input bit lab, input string tag);
        @(negedge clk);
        q_valid = 1'b1;
        q_data  = d;
        @(negedge clk);
        q_valid = 1'b0;
        expect_out(kind, d, ch, lab, tag);
    endtask

    // drop enable for two cycles, load a configuration, re-enable
    task automatic configure(input logic [3:0] sk, input logic [4:0] na,
                             input logic [3:0] mp, input logic [15:0] mask);
        @(negedge clk);
        cfg_enable     = 1'b0;
        cfg_skip       = sk;
        cfg_num_audio  = na;
        cfg_midi_ports = mp;
        cfg_label_mask = mask;
        cfg_iso_chan   = 6'd5;
        repeat (2) @(negedge clk);
        cfg_enable = 1'b1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; q_valid = 1'b0; q_data = '0; cfg_enable = 1'b1;
        cfg_iso_chan = 6'd5; cfg_skip = 4'd0; cfg_num_audio = 5'd2;
        cfg_midi_ports = 4'd0; cfg_label_mask = 16'h0;
        repeat (3) @(negedge clk);
        check(!aud_valid && !midi_valid, "R1", "strobes in reset",
              {aud_valid, midi_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!aud_valid && !midi_valid, "R1", "strobes after reset",
              {aud_valid, midi_valid}, 0);
        send_q(32'h1111_0000, K_AUD, 0, 1'b0, "R1");
    endtask

    // skip 2, three audio channels, no MIDI, two blocks
    task automatic t_skip_audio;
        configure(4'd2, 5'd3, 4'd0, 16'b101);
        for (int b = 0; b < 2; b++) begin
            send_q(32'hDEAD_0000 + b, K_NONE, 0, 1'b0, "R2");
            send_q(32'hDEAD_0010 + b, K_NONE, 0, 1'b0, "R2");
            send_q(32'h0123_4567 + b, K_AUD, 0, 1'b1, "R3");
            send_q(32'h89AB_CDEF + b, K_AUD, 1, 1'b0, "R3");
            send_q(32'hFF00_00FF + b, K_AUD, 2, 1'b1, "R3");
        end
    endtask

    // MIDI word after audio; count 8 then 0 on the same stream
    task automatic t_midi;
        configure(4'd0, 5'd2, 4'd8, 16'h0);
        for (int b = 0; b < 2; b++) begin
            send_q(32'hA000_0000 + b, K_AUD, 0, 1'b0, "R4");
            send_q(32'hA000_0100 + b, K_AUD, 1, 1'b0, "R4");
            send_q(32'h3355_7799 + b, K_MIDI, 0, 1'b0, "R4");
        end
        configure(4'd0, 5'd2, 4'd0, 16'h0);
        for (int b = 0; b < 2; b++) begin
            send_q(32'hB000_0000 + b, K_AUD, 0, 1'b0, "R4");
            send_q(32'hB000_0100 + b, K_AUD, 1, 1'b0, "R4");
        end
    endtask

    task automatic t_unused;
        configure(4'd0, 5'd2, 4'd1, 16'hFFFF);
        cfg_iso_chan = 6'h3F;
        for (int i = 0; i < 4; i++)
            send_q(32'hC000_0000 + i, K_NONE, 0, 1'b0, "R5");
    endtask

    // disable in mid-block, then the next block starts at position 0
    task automatic t_enable;
        configure(4'd1, 5'd2, 4'd0, 16'h0);
        send_q(32'hE000_0000, K_NONE, 0, 1'b0, "R6");
        send_q(32'hE000_0001, K_AUD, 0, 1'b0, "R6");
        cfg_enable = 1'b0;
        send_q(32'hE000_0002, K_NONE, 0, 1'b0, "R6");
        @(negedge clk);
        cfg_enable = 1'b1;
        send_q(32'hE000_0003, K_NONE, 0, 1'b0, "R6");
        send_q(32'hE000_0004, K_AUD, 0, 1'b0, "R6");
        send_q(32'hE000_0005, K_AUD, 1, 1'b0, "R6");
    endtask

    // label mask changed while running
    task automatic t_label_live;
        configure(4'd0, 5'd2, 4'd0, 16'b00);
        send_q(32'hF000_0000, K_AUD, 0, 1'b0, "R7");
        cfg_label_mask = 16'b10;
        send_q(32'hF000_0001, K_AUD, 1, 1'b1, "R7");
        cfg_label_mask = 16'b01;
        send_q(32'hF000_0002, K_AUD, 0, 1'b1, "R7");
        send_q(32'hF000_0003, K_AUD, 1, 1'b0, "R7");
    endtask

    // continuous burst: skip 1, two audio, MIDI; same roles as with gaps
    task automatic t_burst;
        int          kind_prev;
        int          ch_prev;
        logic [31:0] d_prev;
        configure(4'd1, 5'd2, 4'd3, 16'b10);
        kind_prev = K_NONE; ch_prev = 0; d_prev = '0;
        for (int i = 0; i <= 8; i++) begin
            @(negedge clk);
            if (i > 0) expect_out(kind_prev, d_prev, ch_prev, ch_prev == 1, "R8");
            if (i < 8) begin
                q_valid = 1'b1;
                q_data  = 32'h5000_0000 + 32'(i);
                d_prev  = q_data;
                case (i % 4)
                    0:       begin kind_prev = K_NONE; ch_prev = 0; end
                    1:       begin kind_prev = K_AUD;  ch_prev = 0; end
                    2:       begin kind_prev = K_AUD;  ch_prev = 1; end
                    default: begin kind_prev = K_MIDI; ch_prev = 0; end
                endcase
            end else begin
                q_valid = 1'b0;
            end
        end
        @(negedge clk);
        check(!aud_valid && !midi_valid, "R8", "idle after burst",
              {aud_valid, midi_valid}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_skip_audio();
        t_midi();
        t_unused();
        t_enable();
        t_label_live();
        t_burst();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule